// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector

This block compares a divided oscillator strobe with a reference strobe and produces the control for a three-state charge-pump pad. When the divided signal arrives first, the block enables the high drive. When the reference arrives first, it enables the low drive. When neither is pending, or when the pending error is inside the dead zone, both drives are off and the pad enable is low, so the pad floats at high impedance. Both strobes are single-cycle pulses that are already synchronous to `clk`.

A two-bit dead-zone select hides the first 0 to 3 cycles of every error pulse. Error pulses shorter than the window never reach the pad. The same pulse-width count drives a lock monitor. Any error pulse that outlasts `UNLOCK_CYC` cycles raises a sticky unlock flag, and the flag stays set until the controller reads it with `unlock_ack`. When a pending pulse sees a second strobe on its own side, the loop has missed a whole period. The detector then drops both phase flops and starts fresh, which breaks a deadlock.

There is no data stream here, so all pins are plain control and status signals with no valid/ready handshake.

Top module: `pfd_tristate`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it is released, `drv_hi`, `drv_lo`, `pad_oe` and `unlock` are all 0.
- R2: From idle with `dz_sel`=0, a `div_stb` without `ref_stb` sets `drv_hi`=1 from the next cycle on. `drv_hi` stays 1 until the cycle after the matching `ref_stb`, and `drv_lo` stays 0 throughout.
- R3: From idle with `dz_sel`=0, a `ref_stb` without `div_stb` sets `drv_lo`=1 from the next cycle on. `drv_lo` stays 1 until the cycle after the matching `div_stb`, and `drv_hi` stays 0 throughout.
- R4: `pad_oe` is 1 exactly when one of `drv_hi` or `drv_lo` is 1. The two drives are never 1 together. `pad_oe`=0 means high impedance.
- R5: With `dz_sel`=k (0..3), the first k cycles of an error pulse produce no drive. An error pulse of k cycles or fewer produces no drive at all.
- R6: An error pulse that is still pending after `UNLOCK_CYC` cycles (default 6) sets `unlock` to 1 on the following cycle.
- R7: Once set, `unlock` stays 1 until a cycle with `unlock_ack`=1. It reads 0 from the next cycle on, unless a new unlock condition occurs in the same cycle as the ack, and that new condition takes priority.
- R8: While the low drive is pending, a second `ref_stb` without `div_stb` clears the detector to idle on the next cycle. While the high drive is pending, a second `div_stb` without `ref_stb` does the same.
- R9: When both strobes arrive in the same cycle from idle, or when the opposite strobe ends a pending pulse, the detector returns to idle with no drive on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb | input | 1 | Single-cycle reference strobe |
| div_stb | input | 1 | Single-cycle divided-oscillator strobe |
| dz_sel | input | 2 | Dead-zone width in cycles, 0 to 3 |
| unlock_ack | input | 1 | Read strobe that clears the unlock flag |
| drv_hi | output | 1 | Enable for the pad high driver |
| drv_lo | output | 1 | Enable for the pad low driver |
| pad_oe | output | 1 | Pad output enable; 0 means high impedance |
| unlock | output | 1 | Sticky unlock indication |

## Verification
A strobe changes the phase flops at the next rising edge. The drive enables are combinational from those flops and the width count, so they are due one cycle after the strobe, and the dead zone delays them by a further `dz_sel` cycles. The unlock flag follows one cycle after the width count reaches `UNLOCK_CYC`, and an ack takes effect one cycle after it is presented. The bench keeps these latencies by driving inputs and comparing all four outputs on the falling edge against a behavioural model that it advances on the rising edge. Directed sequences cover each corner, and a long random run mixes strobes, dead-zone changes and acks.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Pending phase error: lead = divided strobe came first, lag = reference first
  typedef struct packed {
    logic lead;
    logic lag;
  } phase_t;

  localparam phase_t PH_IDLE = '{lead: 1'b0, lag: 1'b0};
endpackage

// File: rtl/pfd_phase_core.sv
module pfd_phase_core
  import pfd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ref_stb,
  input  logic   div_stb,
  output phase_t ph
);
  phase_t ph_nxt;
  logic   stale;

  // A repeated strobe on the already-pending side means a whole period was missed
  assign stale = (ph.lead && div_stb && !ref_stb) || (ph.lag && ref_stb && !div_stb);

  always_comb begin
    ph_nxt = PH_IDLE;
    if (!stale) begin
      ph_nxt.lead = ph.lead | div_stb;
      ph_nxt.lag  = ph.lag  | ref_stb;
      if (ph_nxt.lead && ph_nxt.lag) ph_nxt = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_IDLE;
    else        ph <= ph_nxt;
  end

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph.lead && ph.lag)); // R9
  AST_LEAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!ph.lead && !ph.lag && div_stb && !ref_stb) |=> ph.lead); // R2
  AST_LAG_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!ph.lead && !ph.lag && ref_stb && !div_stb) |=> ph.lag); // R3
  AST_STALE_LAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ph.lag && ref_stb && !div_stb) |=> (!ph.lag && !ph.lead)); // R8
  AST_STALE_LEAD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ph.lead && div_stb && !ref_stb) |=> (!ph.lag && !ph.lead)); // R8
  AST_OPPOSITE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (ph.lead && ref_stb) |=> !ph.lead); // R9
endmodule

// File: rtl/pfd_width_timer.sv
module pfd_width_timer #(
  parameter int LIMIT = 6,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);

  // Counts the cycles of the current error pulse, saturating at LIMIT
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!active)     cnt <= '0;
    else if (cnt != CMAX) cnt <= cnt + CW'(1);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != CMAX) |=> cnt == $past(cnt) + CW'(1)); // R6
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> cnt == '0); // R5
endmodule

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor #(
  parameter int LIMIT = 6,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [CW-1:0] cnt,
  input  logic          ack,
  output logic          flag
);
  logic hit;

  assign hit = active && (cnt >= CW'(LIMIT));

  // Set takes priority over a simultaneous read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (ack) flag <= 1'b0;
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ack) |=> flag); // R7
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !flag); // R7
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate
  import pfd_pkg::*;
#(
  parameter int UNLOCK_CYC = 6,
  parameter int DZ_W       = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_stb,
  input  logic            div_stb,
  input  logic [DZ_W-1:0] dz_sel,
  input  logic            unlock_ack,
  output logic            drv_hi,
  output logic            drv_lo,
  output logic            pad_oe,
  output logic            unlock
);
  localparam int CNT_W = $clog2(UNLOCK_CYC + 1);
  localparam int CMP_W = (CNT_W > DZ_W) ? CNT_W : DZ_W;

  phase_t           ph;
  logic [CNT_W-1:0] pw_cnt;
  logic             active;
  logic             past_dz;

  pfd_phase_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_stb (ref_stb),
    .div_stb (div_stb),
    .ph      (ph)
  );

  assign active = ph.lead | ph.lag;

  pfd_width_timer #(.LIMIT(UNLOCK_CYC), .CW(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .cnt    (pw_cnt)
  );

  pfd_lock_monitor #(.LIMIT(UNLOCK_CYC), .CW(CNT_W)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .cnt    (pw_cnt),
    .ack    (unlock_ack),
    .flag   (unlock)
  );

  // Dead zone: the pulse must have lasted dz_sel cycles before it reaches the pad
  assign past_dz = CMP_W'(pw_cnt) >= CMP_W'(dz_sel);
  assign drv_hi  = ph.lead && !ph.lag && past_dz;
  assign drv_lo  = ph.lag && !ph.lead && past_dz;
  assign pad_oe  = drv_hi | drv_lo;

  AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_hi && drv_lo)); // R4
  AST_DZ_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (dz_sel == '0 && ph.lead) |-> pad_oe); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!pad_oe && !unlock)); // R1
endmodule

// File: tb/pfd_tristate_tb_top.sv
`timescale 1ns/1ps
module pfd_tristate_tb_top;
  localparam int UNL = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_stb = 1'b0, div_stb = 1'b0, unlock_ack = 1'b0;
  logic [1:0] dz_sel = 2'd0;
  logic       drv_hi, drv_lo, pad_oe, unlock;

  int n_run = 0, n_fail = 0, cyc = 0;
  string cur = "R1";

  // behavioural model state
  bit mL = 0, mG = 0, mU = 0;
  int mpw = 0;

  pfd_tristate #(.UNLOCK_CYC(UNL), .DZ_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .div_stb(div_stb),
    .dz_sel(dz_sel), .unlock_ack(unlock_ack),
    .drv_hi(drv_hi), .drv_lo(drv_lo), .pad_oe(pad_oe), .unlock(unlock)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    bit hit;
    if (!rst_n) begin
      mL = 0; mG = 0; mpw = 0; mU = 0;
    end else begin
      hit = (mL || mG) && (mpw >= UNL);
      if (hit) mU = 1;
      else if (unlock_ack) mU = 0;
      if (mL || mG) begin
        if (mpw < UNL) mpw = mpw + 1;
      end else mpw = 0;
      if ((mL && div_stb && !ref_stb) || (mG && ref_stb && !div_stb)) begin
        mL = 0; mG = 0;
      end else begin
        mL = mL || div_stb;
        mG = mG || ref_stb;
        if (mL && mG) begin mL = 0; mG = 0; end
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string what, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, what, cyc, act, exp);
    end
  endtask

  task automatic compare();
    bit eh, el;
    eh = rst_n && mL && !mG && (mpw >= int'(dz_sel));
    el = rst_n && mG && !mL && (mpw >= int'(dz_sel));
    chk(drv_hi, eh, "drv_hi", cur);
    chk(drv_lo, el, "drv_lo", cur);
    chk(pad_oe, eh | el, "pad_oe", "R4");
    chk(unlock, mU, "unlock", cur);
  endtask

  task automatic step(input logic r, input logic d, input logic [1:0] z, input logic a);
    @(negedge clk);
    cyc++;
    compare();
    ref_stb = r; div_stb = d; dz_sel = z; unlock_ack = a;
  endtask

  task automatic idle(input int n, input logic [1:0] z);
    for (int i = 0; i < n; i++) step(0, 0, z, 0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
    finish_run();
  end

  initial begin
    cur = "R1";
    idle(4, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3, 0);

    cur = "R2";
    step(0, 1, 0, 0); idle(3, 0); step(1, 0, 0, 0); idle(3, 0);
    cur = "R3";
    step(1, 0, 0, 0); idle(2, 0); step(0, 1, 0, 0); idle(3, 0);
    cur = "R9";
    step(1, 1, 0, 0); idle(3, 0);
    step(0, 1, 0, 0); step(1, 0, 0, 0); idle(2, 0);

    cur = "R5";
    for (int z = 0; z < 4; z++) begin
      step(0, 1, 2'(z), 0); idle(2, 2'(z)); step(1, 0, 2'(z), 0); idle(3, 2'(z));
      step(1, 0, 2'(z), 0); idle(1, 2'(z)); step(0, 1, 2'(z), 0); idle(3, 2'(z));
    end

    cur = "R6";
    step(0, 1, 0, 0); idle(UNL + 3, 0); step(1, 0, 0, 0); idle(3, 0);
    chk(unlock, 1'b1, "unlock explicit", "R6");
    cur = "R7";
    idle(4, 0);
    step(0, 0, 0, 1); idle(1, 0);
    chk(unlock, 1'b0, "unlock after ack", "R7");
    step(1, 0, 0, 0); idle(UNL + 1, 0);
    step(0, 0, 0, 1); idle(1, 0);
    chk(unlock, 1'b1, "unlock set beats ack", "R7");
    step(0, 1, 0, 0); step(0, 0, 0, 1); idle(2, 0);

    cur = "R8";
    step(1, 0, 0, 0); idle(3, 0); step(1, 0, 0, 0); idle(1, 0);
    chk(drv_lo, 1'b0, "drv_lo after stale ref", "R8");
    idle(2, 0);
    step(0, 1, 0, 0); idle(2, 0); step(0, 1, 0, 0); idle(1, 0);
    chk(drv_hi, 1'b0, "drv_hi after stale div", "R8");
    idle(2, 0);

    cur = "random";
    for (int i = 0; i < 4000; i++) begin
      int rr;
      rr = int'($urandom_range(0, 99));
      step(rr < 12, (rr >= 8) && (rr < 20), 2'($urandom_range(0, 3)), $urandom_range(0, 15) == 0);
    end
    idle(2, 0);
    finish_run();
  end
endmodule